// File: doc/BRIEF.md
# Horizontal Sync Regenerator

This block sits on the pixel clock behind a video sampler. It receives a raw horizontal sync whose active level is not known in advance, works out for itself which level is the sync pulse, and rebuilds a clean sync of its own. The rebuilt pulse has a programmable width in pixel clocks and a selectable output polarity. Each pixel word travels through a fixed-latency pipeline, and the rebuilt sync is timed so that its leading edge comes out in the same cycle as the word that was sampled with the incoming leading edge.

Polarity is found by measuring the two levels of the synchronized sync over each full period, taken from one rising edge to the next. The shorter level is taken as the pulse. The decision changes only at the end of a period. The measuring counters stop at their maximum value, so a sync that goes missing for a long time cannot wrap them into a false decision. A data-valid flag stays low until the pipeline holds only words sampled after reset.

Top module: `hsync_regen`

## Requirements
- R1: With the default depth of 5 register stages, the word on `pix_in` at rising edge n is on `pix_out` in the cycle after edge n+4.
- R2: `pix_valid` is low after reset. It rises after the fifth rising edge with reset low and then stays high until the next reset.
- R3: `in_active_high` is 1 when the high level of the synchronized sync lasted fewer cycles than the low level over the last full period, and 0 when the low level was shorter. The value is updated only at a rising edge of the synchronized sync. A tie keeps the previous value, and the first rising edge after reset only starts the measurement.
- R4: If rising edge n is the first to sample `sync_in` at the detected active level, the regenerated pulse becomes active in the cycle after edge n+4. This is the cycle in which `pix_out` carries the word sampled at edge n.
- R5: For a width setting W between 1 and 255, the pulse stays active for exactly W cycles. W is read from `pulse_width` at the edge where the pulse begins.
- R6: A width setting of 0 at the edge where a pulse would begin produces no pulse.
- R7: A new leading edge that arrives while a pulse is active restarts the pulse, so it then lasts W more cycles from the restart.
- R8: `sync_out` equals `out_active_high` while the pulse is active and its inverse while the pulse is idle. It follows changes of `out_active_high` in the same cycle.
- R9: The high-time and low-time counters saturate at 2^CNT_W-1. A level longer than this is treated as being that long and never wraps.
- R10: A synchronous reset clears every counter and the pipeline (`pix_out` = 0). It sets the detected polarity to active-low (`in_active_high` = 0), drives `pix_valid` low and leaves the pulse idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_in | input | 1 | Raw horizontal sync, polarity unknown |
| pix_in | input | DATA_W | Pixel word sampled on this clock |
| pulse_width | input | WIDTH_W | Regenerated pulse width in pixel clocks, 0 = no pulse |
| out_active_high | input | 1 | 1: output sync active high, 0: active low |
| pix_out | output | DATA_W | Pixel word delayed by the pipeline |
| sync_out | output | 1 | Regenerated sync |
| pix_valid | output | 1 | Pipeline filled since reset |
| in_active_high | output | 1 | Detected input polarity, 1 = active high |

## Verification
The hardest case to reach from the ports is a level long enough to saturate a measuring counter. A counter that wrapped would look like a short level and reverse the polarity decision. The bench builds the block with a narrow counter and drives active-high lines whose low level runs just past the counter range. A wrapped count there would fall below the pulse length, so any wrap shows up as a flipped `in_active_high`. Polarity changes between segments are exercised as well, and the pulse timing is compared only after the block has seen enough lines to settle.

// File: rtl/hsr_pkg.sv
package hsr_pkg;

   // Sync level convention used throughout the block
   typedef enum logic {
      LVL_LOW  = 1'b0,
      LVL_HIGH = 1'b1
   } hsr_level_e;

   // Reset assumption for the incoming sync
   localparam hsr_level_e RESET_IN_LEVEL = LVL_LOW;

endpackage

// File: rtl/hsr_sync2.sv
module hsr_sync2 #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("hsr_sync2: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d};
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/hsr_delay_line.sv
module hsr_delay_line #(
   parameter int W     = 8,
   parameter int DEPTH = 5
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("hsr_delay_line: W must be positive");
   end
   if (DEPTH < 0) begin : g_bad_depth
      $error("hsr_delay_line: DEPTH must not be negative");
   end

   if (DEPTH == 0) begin : g_wire
      assign q = d;
   end else begin : g_regs
      logic [W-1:0] stage_q [DEPTH];

      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
         always_ff @(posedge clk) begin
            if (rst) begin
               stage_q[i] <= '0;
            end else if (i == 0) begin
               stage_q[i] <= d;
            end else begin
               stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
            end
         end
      end

      assign q = stage_q[DEPTH-1];
   end

endmodule

// File: rtl/hsr_pol_detect.sv
module hsr_pol_detect
   import hsr_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic clk,
   input  logic rst,
   input  logic lvl,        // synchronized sync level
   output logic pol_high,   // 1: pulse is the high level
   output logic lead        // leading edge in the detected polarity
);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("hsr_pol_detect: CNT_W must be at least 2");
   end

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic             prev_q;
   logic             seen_q;
   logic             pol_q;
   logic [CNT_W-1:0] hi_q;
   logic [CNT_W-1:0] lo_q;
   logic             rise;
   logic             act_now;
   logic             act_prev;

   function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
      return (v == CNT_MAX) ? v : v + CNT_ONE;
   endfunction

   assign rise     = lvl & ~prev_q;
   assign act_now  = (lvl == pol_q);
   assign act_prev = (prev_q == pol_q);
   assign lead     = act_now & ~act_prev;
   assign pol_high = pol_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q <= 1'b0;
         seen_q <= 1'b0;
         pol_q  <= RESET_IN_LEVEL;
         hi_q   <= '0;
         lo_q   <= '0;
      end else begin
         prev_q <= lvl;
         if (rise) begin
            seen_q <= 1'b1;
            if (seen_q && (hi_q != lo_q)) begin
               pol_q <= (hi_q < lo_q);
            end
            hi_q <= CNT_ONE;
            lo_q <= '0;
         end else if (lvl) begin
            hi_q <= sat_inc(hi_q);
         end else begin
            lo_q <= sat_inc(lo_q);
         end
      end
   end

   // Polarity moves only at the end of a period
   assert_pol_period_end_R3: assert property (@(posedge clk) disable iff (rst)
      !rise |=> $stable(pol_q));

   // Saturated counters hold their value
   assert_hi_saturate_R9: assert property (@(posedge clk) disable iff (rst)
      (hi_q == CNT_MAX && lvl && !rise) |=> (hi_q == CNT_MAX));

   assert_lo_saturate_R9: assert property (@(posedge clk) disable iff (rst)
      (lo_q == CNT_MAX && !lvl) |=> (lo_q == CNT_MAX));

endmodule

// File: rtl/hsr_pulse_gen.sv
module hsr_pulse_gen #(
   parameter int WIDTH_W = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               start,
   input  logic [WIDTH_W-1:0] width,
   input  logic               out_high,
   output logic               sync_out
);

   if (WIDTH_W < 1) begin : g_bad_width
      $error("hsr_pulse_gen: WIDTH_W must be positive");
   end

   localparam logic [WIDTH_W-1:0] W_ONE = {{(WIDTH_W-1){1'b0}}, 1'b1};

   logic [WIDTH_W-1:0] cnt_q;
   logic               active;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= width;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - W_ONE;
      end
   end

   assign active   = (cnt_q != '0);
   assign sync_out = out_high ? active : ~active;

   assert_reset_idle_R10: assert property (@(posedge clk)
      rst |=> (cnt_q == '0));

   assert_zero_width_R6: assert property (@(posedge clk) disable iff (rst)
      (start && width == '0) |=> (cnt_q == '0));

   assert_restart_load_R7: assert property (@(posedge clk) disable iff (rst)
      (start && width != '0) |=> (cnt_q == $past(width)));

   assert_pulse_end_R5: assert property (@(posedge clk) disable iff (rst)
      (cnt_q == W_ONE && !start) |=> (cnt_q == '0));

endmodule

// File: rtl/hsync_regen.sv
module hsync_regen #(
   parameter int DATA_W   = 24,
   parameter int WIDTH_W  = 8,
   parameter int CNT_W    = 12,
   parameter int PIPE_LAT = 5
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               sync_in,
   input  logic [DATA_W-1:0]  pix_in,
   input  logic [WIDTH_W-1:0] pulse_width,
   input  logic               out_active_high,
   output logic [DATA_W-1:0]  pix_out,
   output logic               sync_out,
   output logic               pix_valid,
   output logic               in_active_high
);

   // Sync path: 2 synchronizer flops + edge strobe + STROBE_DLY + output flop
   localparam int SYNC_STAGES = 2;
   localparam int STROBE_DLY  = PIPE_LAT - SYNC_STAGES - 1;
   localparam int FILL_W      = $clog2(PIPE_LAT + 1);
   localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(PIPE_LAT);
   localparam logic [FILL_W-1:0] FILL_ONE = FILL_W'(1);

   if (PIPE_LAT < SYNC_STAGES + 1) begin : g_bad_lat
      $error("hsync_regen: PIPE_LAT too short for the sync path");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("hsync_regen: DATA_W must be positive");
   end

   logic              lvl_sync;
   logic              lead;
   logic [0:0]        lead_vec;
   logic [0:0]        start_vec;
   logic [FILL_W-1:0] fill_q;

   hsr_sync2 #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (sync_in),
      .q   (lvl_sync)
   );

   hsr_pol_detect #(.CNT_W(CNT_W)) u_pol (
      .clk      (clk),
      .rst      (rst),
      .lvl      (lvl_sync),
      .pol_high (in_active_high),
      .lead     (lead)
   );

   assign lead_vec = lead;

   hsr_delay_line #(.W(1), .DEPTH(STROBE_DLY)) u_strobe_dly (
      .clk (clk),
      .rst (rst),
      .d   (lead_vec),
      .q   (start_vec)
   );

   hsr_pulse_gen #(.WIDTH_W(WIDTH_W)) u_pulse (
      .clk      (clk),
      .rst      (rst),
      .start    (start_vec[0]),
      .width    (pulse_width),
      .out_high (out_active_high),
      .sync_out (sync_out)
   );

   hsr_delay_line #(.W(DATA_W), .DEPTH(PIPE_LAT)) u_data_dly (
      .clk (clk),
      .rst (rst),
      .d   (pix_in),
      .q   (pix_out)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         fill_q <= '0;
      end else if (fill_q != FILL_MAX) begin
         fill_q <= fill_q + FILL_ONE;
      end
   end

   assign pix_valid = (fill_q == FILL_MAX);

   assert_valid_hold_R2: assert property (@(posedge clk) disable iff (rst)
      pix_valid |=> pix_valid);

   assert_valid_reset_R10: assert property (@(posedge clk)
      rst |=> !pix_valid);

endmodule

// File: tb/hsync_regen_test.sv
module hsync_regen_test;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 24;
   localparam int WW = 8;
   localparam int CW = 6;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          sync_in = 1'b1;
   logic [DW-1:0] pix_in = '0;
   logic [WW-1:0] pulse_width = 8'd4;
   logic          out_active_high = 1'b1;
   logic [DW-1:0] pix_out;
   logic          sync_out;
   logic          pix_valid;
   logic          in_active_high;

   int n_checks = 0;
   int n_fail   = 0;

   // bench model state
   int            since_rst = 0;
   logic [DW-1:0] ph [5];
   logic          lh [4];
   logic          prev_x = 1'b1;
   int            mcnt = 0;
   logic          exp_pol = 1'b0;
   int            lines_since = 0;
   string         sync_tag = "R4";

   hsync_regen #(.DATA_W(DW), .WIDTH_W(WW), .CNT_W(CW), .PIPE_LAT(5)) uut (
      .clk             (clk),
      .rst             (rst),
      .sync_in         (sync_in),
      .pix_in          (pix_in),
      .pulse_width     (pulse_width),
      .out_active_high (out_active_high),
      .pix_out         (pix_out),
      .sync_out        (sync_out),
      .pix_valid       (pix_valid),
      .in_active_high  (in_active_high)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic exp_sync(input int cnt, input logic oah);
      return (cnt > 0) ? oah : ~oah;
   endfunction

   task automatic tick(input logic s, input logic [DW-1:0] p);
      logic lead;
      logic start;
      sync_in = s;
      pix_in  = p;
      @(posedge clk);
      if (rst) begin
         since_rst = 0;
         mcnt = 0;
         for (int i = 0; i < 5; i++) ph[i] = '0;
         for (int i = 0; i < 4; i++) lh[i] = 1'b0;
      end else begin
         since_rst++;
         for (int i = 4; i > 0; i--) ph[i] = ph[i-1];
         ph[0] = p;
         lead  = (s == exp_pol) && (prev_x != exp_pol);
         start = lh[3];
         for (int i = 3; i > 0; i--) lh[i] = lh[i-1];
         lh[0] = lead;
         mcnt  = start ? int'(pulse_width) : ((mcnt > 0) ? mcnt - 1 : 0);
      end
      prev_x = s;
      @(negedge clk);
      if (!rst) begin
         check(pix_valid == (since_rst >= 5), "R2", pix_valid, since_rst >= 5);
         if (since_rst >= 5)
            check(pix_out == ph[4], "R1", pix_out, ph[4]);
         if (lines_since >= 3)
            check(sync_out == exp_sync(mcnt, out_active_high), sync_tag,
                  sync_out, exp_sync(mcnt, out_active_high));
      end
   endtask

   task automatic set_pol(input logic p);
      if (p != exp_pol) begin
         exp_pol = p;
         lines_since = 0;
      end
   endtask

   // One sync period: a cycles at active level, then b at inactive level
   task automatic line(input int a, input int b, input string pol_tag);
      for (int i = 0; i < a; i++) tick(exp_pol, DW'($urandom));
      for (int i = 0; i < b; i++) tick(~exp_pol, DW'($urandom));
      lines_since++;
      if (lines_since >= 3)
         check(in_active_high == exp_pol, pol_tag, in_active_high, exp_pol);
   endtask

   initial begin
      void'($urandom(32'h1d5e_a7c3));
      // R10: reset state
      rst = 1'b1;
      for (int i = 0; i < 3; i++) tick(1'b1, DW'($urandom));
      check(in_active_high == 1'b0, "R10", in_active_high, 0);
      check(sync_out == 1'b0, "R10", sync_out, 0);
      check(pix_valid == 1'b0, "R10", pix_valid, 0);
      check(pix_out == '0, "R10", pix_out, 0);
      out_active_high = 1'b0;
      #1;
      check(sync_out == 1'b1, "R8", sync_out, 1);
      out_active_high = 1'b1;
      rst = 1'b0;

      // R4: alignment, active-low input, width 3
      set_pol(1'b0);
      pulse_width = 8'd3;
      sync_tag = "R4";
      for (int l = 0; l < 6; l++) line(4, 30, "R3");

      // R6: width zero, active-high input
      set_pol(1'b1);
      pulse_width = 8'd0;
      sync_tag = "R6";
      for (int l = 0; l < 6; l++) line(3, 25, "R3");

      // R8: active-low output, width 6
      pulse_width = 8'd6;
      out_active_high = 1'b0;
      sync_tag = "R8";
      for (int l = 0; l < 5; l++) line(5, 28, "R3");

      // R7: width longer than the period, pulses restart
      out_active_high = 1'b1;
      pulse_width = 8'd10;
      sync_tag = "R7";
      for (int l = 0; l < 8; l++) line(2, 4, "R3");

      // R5: random segments
      sync_tag = "R5";
      for (int seg = 0; seg < 10; seg++) begin
         set_pol(1'($urandom));
         pulse_width = WW'($urandom % 13);
         out_active_high = 1'($urandom);
         for (int l = 0; l < 5; l++)
            line(2 + int'($urandom % 7), 20 + int'($urandom % 30), "R3");
      end

      // R9: low level longer than the counter range, active-high input
      set_pol(1'b1);
      pulse_width = 8'd4;
      out_active_high = 1'b1;
      sync_tag = "R5";
      for (int l = 0; l < 3; l++) line(5, 30, "R3");
      for (int l = 0; l < 4; l++) begin
         line(5, 66, "R9");
         check(in_active_high == 1'b1, "R9", in_active_high, 1);
      end

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule